// File: doc/BRIEF.md
# Power-of-Two Clock Output Divider

This block takes the selected oscillator, which is modelled as its own clock, and derives two signals from it. The first is a square wave for a shared pin, whose rate is set by a 4-bit exponent code. The second is a single-cycle enable tick that paces an LED timebase, whose rate is set by a separate 3-bit exponent. One free-running counter serves both. The two extreme output codes turn the pin into a static output held at 0 or at 1. A direction bit tells the pad whether the pin drives the oscillator out or takes it in.

The oscillator counts as running only when the source select names the external input and that input is present, or names the internal oscillator and that oscillator is enabled. With source off or the reserved code, the LED tick stays low and every dynamic pin code yields 0. A change to the source select, the output code or the LED exponent restarts the counter from zero, so the new rate begins on a clean boundary.

Top module: `osc_outdiv`

## Requirements
- R1: The oscillator runs only when `src_sel` is 2'b01 with `ext_present` high, or 2'b10 with `int_osc_en` high. Codes 2'b00 and 2'b11 mean off. While off, `led_tick` is 0, and `pin_val` is 0 for every output code from 1 to 14.
- R2: Output code 4'h0 drives `pin_val` to a constant 0, and code 4'hF drives it to a constant 1. Both hold whatever the source and reset state.
- R3: Output code 4'h1 passes the running clock straight to `pin_val`: 1 while `clk` is high and 0 while it is low.
- R4: Output code n from 2 to 14 gives a 50% duty square wave on `pin_val` with a period of 2^(n-1) clock cycles.
- R5: LED exponent 3'd0 keeps `led_tick` at 0.
- R6: LED exponent m from 1 to 7 makes `led_tick` a one-cycle pulse every 2^(m-1) cycles, so m = 1 gives a pulse on every cycle.
- R7: A change to `src_sel`, `out_code` or `led_exp` restarts the counter. Take the first rising edge after the change as edge 1. The first tick is seen after edge 2^(m-1). With code n, `pin_val` stays 0 through edge 2^(n-2) and first becomes 1 after edge 2^(n-2)+1.
- R8: `pin_oe` follows `pin_out_mode`: 1 makes the pin an oscillator output, 0 makes it an input.
- R9: While `rst_n` is low, `led_tick` is 0 and every dynamic output code gives `pin_val` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected oscillator, modelled as the block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_present | input | 1 | External clock input is present |
| int_osc_en | input | 1 | Internal oscillator is enabled |
| src_sel | input | 2 | Source select: 00 off, 01 external, 10 internal, 11 reserved (off) |
| pin_out_mode | input | 1 | Pin direction: 1 output, 0 input |
| out_code | input | 4 | Pin output exponent code |
| led_exp | input | 3 | LED tick exponent |
| pin_val | output | 1 | Value driven on the shared pin |
| pin_oe | output | 1 | Pin direction select to the pad |
| led_tick | output | 1 | Single-cycle LED timebase enable |

## Verification
The main function is tried with source, presence and enable combinations in which only one factor differs from a running case. This separates a source that is really running from one that is selected but absent or disabled, and from the off and reserved codes. Dynamic codes and LED exponents are measured over fixed windows by counting high samples and ticks. Because each window covers whole periods, a wrong tap or a wrong exponent offset changes the count while the phase does not. Directed sequences count edges after a configuration change to separate a true restart from a counter left running, and check the wrap of the widest code.

// File: rtl/osc_outdiv.sv
module osc_outdiv #(
  parameter int CODE_W = 4,
  parameter int LED_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_present,
  input  logic              int_osc_en,
  input  logic [1:0]        src_sel,
  input  logic              pin_out_mode,
  input  logic [CODE_W-1:0] out_code,
  input  logic [LED_W-1:0]  led_exp,
  output logic              pin_val,
  output logic              pin_oe,
  output logic              led_tick
);
  localparam int CNT_W = (1 << CODE_W) - 3;
  localparam int CFG_W = 2 + CODE_W + LED_W;
  localparam logic [CODE_W-1:0] CODE_HI = '1;

  logic [CNT_W-1:0] cnt;
  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] tap_mask, led_mask;

  wire [CFG_W-1:0] cfg_now = {src_sel, out_code, led_exp};
  wire osc_on = (src_sel == 2'b01 && ext_present) || (src_sel == 2'b10 && int_osc_en);
  wire run = osc_on && rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (!osc_on || cfg_now != cfg_q) cnt <= '0;
      else                             cnt <= cnt + CNT_W'(1);
    end
  end

  assign tap_mask = CNT_W'(1) << (out_code - CODE_W'(2));
  assign led_mask = (CNT_W'(1) << (led_exp - LED_W'(1))) - CNT_W'(1);

  always_comb begin
    if (out_code == '0)               pin_val = 1'b0;
    else if (out_code == CODE_HI)     pin_val = 1'b1;
    else if (!run)                    pin_val = 1'b0;
    else if (out_code == CODE_W'(1))  pin_val = clk;
    else                              pin_val = |(cnt & tap_mask);
  end

  assign led_tick = run && (led_exp != '0) && ((cnt & led_mask) == led_mask);
  assign pin_oe   = pin_out_mode;
endmodule

module osc_outdiv_chk #(
  parameter int CODE_W = 4,
  parameter int LED_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_present,
  input logic              int_osc_en,
  input logic [1:0]        src_sel,
  input logic              pin_out_mode,
  input logic [CODE_W-1:0] out_code,
  input logic [LED_W-1:0]  led_exp,
  input logic              pin_val,
  input logic              pin_oe,
  input logic              led_tick
);
  localparam logic [CODE_W-1:0] CODE_HI = '1;
  wire act = (src_sel == 2'b01 && ext_present) || (src_sel == 2'b10 && int_osc_en);
  wire [2+CODE_W+LED_W-1:0] cfg = {src_sel, out_code, led_exp};

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !led_tick);
  assert_static_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_code == '0 |-> !pin_val);
  assert_static_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_code == CODE_HI |-> pin_val);
  assert_half_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act) && $past(rst_n) && $past(rst_n, 2) && out_code == CODE_W'(2)
     && $past(out_code) == CODE_W'(2) && $past(cfg) == $past(cfg, 2))
    |-> pin_val != $past(pin_val));
  assert_led_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    led_exp == '0 |-> !led_tick);
  assert_led_every_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act && led_exp == LED_W'(1)) |-> led_tick);
  assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(led_tick) && $past(led_exp) > LED_W'(1) && led_exp > LED_W'(1)) |-> !led_tick);
  assert_dir_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(pin_out_mode) |-> $changed(pin_oe));
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> !led_tick);
endmodule

bind osc_outdiv osc_outdiv_chk #(.CODE_W(CODE_W), .LED_W(LED_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ext_present(ext_present), .int_osc_en(int_osc_en),
  .src_sel(src_sel), .pin_out_mode(pin_out_mode), .out_code(out_code),
  .led_exp(led_exp), .pin_val(pin_val), .pin_oe(pin_oe), .led_tick(led_tick));

// File: tb/osc_outdiv_tb.sv
module osc_outdiv_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, ext_present = 1'b0, int_osc_en = 1'b0, pin_out_mode = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [3:0] out_code = 4'h0;
  logic [2:0] led_exp = 3'd0;
  logic pin_val, pin_oe, led_tick;
  int errs = 0, checks = 0;

  osc_outdiv dut_i (.clk(clk), .rst_n(rst_n), .ext_present(ext_present), .int_osc_en(int_osc_en),
    .src_sel(src_sel), .pin_out_mode(pin_out_mode), .out_code(out_code), .led_exp(led_exp),
    .pin_val(pin_val), .pin_oe(pin_oe), .led_tick(led_tick));

  always #4 clk = ~clk;

  // {src, ext, int, code, exp, high samples in 64, ticks in 64}
  localparam logic [26:0] VEC [11] = '{
    {2'b10, 1'b0, 1'b1, 4'd2,  3'd1, 8'd32, 8'd64},
    {2'b10, 1'b0, 1'b1, 4'd3,  3'd2, 8'd32, 8'd32},
    {2'b01, 1'b1, 1'b0, 4'd5,  3'd4, 8'd32, 8'd8},
    {2'b01, 1'b1, 1'b0, 4'd7,  3'd7, 8'd32, 8'd1},
    {2'b00, 1'b1, 1'b1, 4'd3,  3'd2, 8'd0,  8'd0},
    {2'b11, 1'b1, 1'b1, 4'd3,  3'd2, 8'd0,  8'd0},
    {2'b10, 1'b0, 1'b1, 4'd0,  3'd0, 8'd0,  8'd0},
    {2'b00, 1'b0, 1'b0, 4'd15, 3'd3, 8'd64, 8'd0},
    {2'b10, 1'b0, 1'b1, 4'd1,  3'd0, 8'd64, 8'd0},
    {2'b01, 1'b0, 1'b1, 4'd2,  3'd1, 8'd0,  8'd0},
    {2'b10, 1'b1, 1'b0, 4'd2,  3'd1, 8'd0,  8'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setcfg(input logic [1:0] s, input logic e, input logic i,
                        input logic [3:0] c, input logic [2:0] m);
    @(negedge clk);
    src_sel = s; ext_present = e; int_osc_en = i; out_code = c; led_exp = m;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ones, ticks;
    src_sel = 2'b10; int_osc_en = 1'b1; out_code = 4'd2; led_exp = 3'd1;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 tick in reset", led_tick, 0);
    chk("R9 pin in reset", pin_val, 0);
    chk("R8 direction input", pin_oe, 0);
    pin_out_mode = 1'b1; #1;
    chk("R8 direction output", pin_oe, 1);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < 11; v++) begin
      setcfg(VEC[v][26:25], VEC[v][24], VEC[v][23], VEC[v][22:19], VEC[v][18:16]);
      repeat (4) @(posedge clk);
      ones = 0; ticks = 0;
      for (int k = 0; k < 64; k++) begin
        @(posedge clk); #2;
        ones += int'(pin_val);
        ticks += int'(led_tick);
      end
      chk($sformatf("R1 R2 R3 R4 pin highs vector %0d", v), ones, VEC[v][15:8]);
      chk($sformatf("R1 R5 R6 tick count vector %0d", v), ticks, VEC[v][7:0]);
    end

    setcfg(2'b10, 1'b0, 1'b1, 4'd1, 3'd0);
    @(negedge clk); #2;
    chk("R3 passthrough low phase", pin_val, 0);
    @(posedge clk); #2;
    chk("R3 passthrough high phase", pin_val, 1);

    setcfg(2'b10, 1'b0, 1'b1, 4'd2, 3'd3);
    for (int e = 1; e <= 4; e++) begin
      @(posedge clk); #2;
      chk($sformatf("R7 first tick edge %0d", e), led_tick, (e == 4) ? 1 : 0);
    end
    repeat (5) @(posedge clk);
    setcfg(2'b10, 1'b0, 1'b1, 4'd2, 3'd4);
    ticks = 0;
    for (int e = 1; e <= 7; e++) begin
      @(posedge clk); #2;
      ticks += int'(led_tick);
    end
    chk("R7 no tick before restart period", ticks, 0);
    @(posedge clk); #2;
    chk("R7 tick after restart period", led_tick, 1);

    setcfg(2'b10, 1'b0, 1'b1, 4'd14, 3'd0);
    repeat (4096) @(posedge clk);
    #2;
    chk("R7 widest code still low", pin_val, 0);
    @(posedge clk); #2;
    chk("R7 widest code first high", pin_val, 1);
    repeat (4095) @(posedge clk);
    #2;
    chk("R4 widest code end of high half", pin_val, 1);
    @(posedge clk); #2;
    chk("R4 widest code wraps low", pin_val, 0);

    @(negedge clk) ext_present = 1'b0; src_sel = 2'b01; out_code = 4'd15; #1;
    chk("R2 static high with source off", pin_val, 1);
    finish_run();
  end
endmodule